// File: doc/BRIEF.md
# Load-Use Hazard Interlock

This block sits beside the decode stage of a five-stage in-order integer pipeline. It finds the one read-after-write case that operand bypassing cannot cover: a load in the execute stage whose destination register is a source of the instruction directly behind it in decode. The load data only exists at the end of the memory stage, so the consumer must wait one cycle.

The block is purely combinational. It decodes the opcode class of both pipeline registers. It compares the load's destination against the consumer's `rs` field, and also against its `rt` field when that class actually reads `rt`. When the hazard is present it holds the program counter and the fetch/decode register, and it turns the decode/execute entry into a bubble. On the following cycle the load has moved on to the memory stage, the bubble sits in execute, and the stall drops by itself.

Fields are fixed by behaviour. The opcode is the top six bits `[31:26]`, `rs` is `[25:21]` and `rt` is `[20:16]`. Field positions and widths are parameters.

Top module: `load_use_interlock`

## Requirements
- R1: A stall is raised when all of the following hold. Both stages are valid. The execute-stage opcode has top three bits `100` (load group). Its `rt` is nonzero and equals the decode-stage `rs`. The decode-stage opcode is `000000` (register ALU), `001xxx` (immediate ALU), `100xxx` (load), `101xxx` (store) or `0001xx` (branch).
- R2: The load's `rt` is also compared with the decode-stage `rt` for opcodes `000000`, `101xxx`, `000100` and `000101`. It is not compared for `001xxx`, `100xxx`, `000110` or `000111`.
- R3: A decode-stage opcode outside the classes of R1 never causes a stall, for example `000010`, `000011`, `01xxxx` or `11xxxx`.
- R4: An execute-stage opcode whose top three bits are not `100` never causes a stall.
- R5: A load whose `rt` is register 0 never causes a stall.
- R6: If either valid input is low, no stall is raised.
- R7: During a stall `pc_we`=0, `ifid_we`=0 and `idex_bubble`=1. Otherwise the three outputs are 1, 1 and 0. The outputs follow the inputs in the same cycle.
- R8: In a pipeline that obeys the outputs, each load-use pair stalls for exactly one cycle, and the dependent instruction enters execute exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ifid_instr | input | INSTR_W | Instruction word held in the fetch/decode register |
| ifid_valid | input | 1 | Fetch/decode register holds a real instruction |
| idex_instr | input | INSTR_W | Instruction word held in the decode/execute register |
| idex_valid | input | 1 | Decode/execute register holds a real instruction |
| pc_we | output | 1 | Program counter may advance |
| ifid_we | output | 1 | Fetch/decode register may load |
| idex_bubble | output | 1 | Load a no-op with register write cleared into decode/execute |

## Verification
The bench builds the block with the default 32-bit word and the standard field layout. This makes all 64 producer opcodes against all 64 consumer opcodes small enough to sweep completely, each pair under rs-match, rt-match, no-match, register-zero and invalid-stage operand patterns. A bench-side pipeline register model then runs short programs through the block, which brings the one-cycle stall length and single issue of the dependent instruction within reach.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

   typedef enum logic [2:0] {
      CC_NONE,
      CC_RREG,
      CC_IMM,
      CC_LOAD,
      CC_STORE,
      CC_BR_PAIR,
      CC_BR_SINGLE
   } cons_class_e;

   localparam logic [2:0] GRP_IMM   = 3'b001;
   localparam logic [2:0] GRP_LOAD  = 3'b100;
   localparam logic [2:0] GRP_STORE = 3'b101;
   localparam logic [5:0] OP_RREG   = 6'b000000;
   localparam logic [3:0] GRP_BR    = 4'b0001;

   function automatic cons_class_e classify(input logic [5:0] op);
      cons_class_e c;
      c = CC_NONE;
      if (op == OP_RREG)                 c = CC_RREG;
      else if (op[5:3] == GRP_IMM)       c = CC_IMM;
      else if (op[5:3] == GRP_LOAD)      c = CC_LOAD;
      else if (op[5:3] == GRP_STORE)     c = CC_STORE;
      else if (op[5:2] == GRP_BR)        c = op[1] ? CC_BR_SINGLE : CC_BR_PAIR;
      return c;
   endfunction

endpackage

// File: rtl/ilk_producer_dec.sv
module ilk_producer_dec #(
   parameter int INSTR_W = 32,
   parameter int OPC_LSB = 26,
   parameter int RT_LSB  = 16,
   parameter int REG_W   = 5
) (
   input  logic [INSTR_W-1:0] instr,
   input  logic               valid,
   output logic               load_live,
   output logic [REG_W-1:0]   dst
);
   import ilk_pkg::*;

   localparam int OPC_W = 6;

   logic [OPC_W-1:0] opc;
   logic             is_load;

   assign opc     = instr[OPC_LSB +: OPC_W];
   assign dst     = instr[RT_LSB +: REG_W];
   assign is_load = (opc[5:3] == GRP_LOAD);

   assign load_live = valid && is_load && (dst != '0);

   always_comb begin
      // R5: a register-zero destination is never a live producer
      a_r5_zero_dst_dead: assert (!(load_live && dst == '0));
      // R4: only the load group produces a live result
      a_r4_load_group_only: assert (!load_live || opc[5:3] == GRP_LOAD);
   end

endmodule

// File: rtl/ilk_consumer_dec.sv
module ilk_consumer_dec #(
   parameter int INSTR_W = 32,
   parameter int OPC_LSB = 26,
   parameter int RS_LSB  = 21,
   parameter int RT_LSB  = 16,
   parameter int REG_W   = 5,
   parameter int NSRC    = 2
) (
   input  logic [INSTR_W-1:0]        instr,
   output logic [NSRC-1:0]           src_used,
   output logic [NSRC-1:0][REG_W-1:0] src_reg
);
   import ilk_pkg::*;

   localparam int OPC_W = 6;

   cons_class_e      cls;
   logic [OPC_W-1:0] opc;
   logic             reads_rs;
   logic             reads_rt;

   assign opc = instr[OPC_LSB +: OPC_W];
   assign cls = classify(opc);

   always_comb begin
      reads_rs = 1'b0;
      reads_rt = 1'b0;
      unique case (cls)
         CC_RREG:      begin reads_rs = 1'b1; reads_rt = 1'b1; end
         CC_IMM:       begin reads_rs = 1'b1; reads_rt = 1'b0; end
         CC_LOAD:      begin reads_rs = 1'b1; reads_rt = 1'b0; end
         CC_STORE:     begin reads_rs = 1'b1; reads_rt = 1'b1; end
         CC_BR_PAIR:   begin reads_rs = 1'b1; reads_rt = 1'b1; end
         CC_BR_SINGLE: begin reads_rs = 1'b1; reads_rt = 1'b0; end
         default:      begin reads_rs = 1'b0; reads_rt = 1'b0; end
      endcase
   end

   generate
      if (NSRC == 2) begin : g_two_src
         assign src_used = {reads_rt, reads_rs};
         assign src_reg  = {instr[RT_LSB +: REG_W], instr[RS_LSB +: REG_W]};
      end else begin : g_one_src
         assign src_used = reads_rs;
         assign src_reg  = instr[RS_LSB +: REG_W];
      end
   endgenerate

   always_comb begin
      // R2: immediate ALU and load consumers never present rt
      a_r2_no_rt_for_imm_load: assert (!((opc[5:3] == GRP_IMM || opc[5:3] == GRP_LOAD) && src_used[NSRC-1] && NSRC == 2));
      // R3: jumps and unused groups read no register
      a_r3_unknown_reads_none: assert (!(opc[5:4] == 2'b01 || opc[5:4] == 2'b11 || opc[5:1] == 5'b00001) || src_used == '0);
   end

endmodule

// File: rtl/ilk_match.sv
module ilk_match #(
   parameter int REG_W = 5,
   parameter int NSRC  = 2
) (
   input  logic                       load_live,
   input  logic [REG_W-1:0]           dst,
   input  logic [NSRC-1:0]            src_used,
   input  logic [NSRC-1:0][REG_W-1:0] src_reg,
   output logic                       hazard
);
   logic [NSRC-1:0] hit;

   genvar i;
   generate
      for (i = 0; i < NSRC; i++) begin : g_cmp
         assign hit[i] = src_used[i] && (src_reg[i] == dst);
      end
   endgenerate

   assign hazard = load_live && (|hit);

   always_comb begin
      // R1: a hazard always names a used source equal to the load target
      a_r1_hazard_has_hit: assert (!hazard || (hit != '0 && load_live));
   end

endmodule

// File: rtl/load_use_interlock.sv
module load_use_interlock #(
   parameter int INSTR_W = 32,
   parameter int OPC_LSB = 26,
   parameter int RS_LSB  = 21,
   parameter int RT_LSB  = 16,
   parameter int REG_W   = 5,
   parameter int NSRC    = 2
) (
   input  logic [INSTR_W-1:0] ifid_instr,
   input  logic               ifid_valid,
   input  logic [INSTR_W-1:0] idex_instr,
   input  logic               idex_valid,
   output logic               pc_we,
   output logic               ifid_we,
   output logic               idex_bubble
);
   localparam int OPC_W = 6;

   generate
      if (OPC_LSB + OPC_W > INSTR_W) begin : g_bad_opc
         $error("opcode field exceeds instruction width");
      end
      if (RS_LSB + REG_W > INSTR_W || RT_LSB + REG_W > INSTR_W) begin : g_bad_reg
         $error("register field exceeds instruction width");
      end
      if (NSRC < 1 || NSRC > 2) begin : g_bad_nsrc
         $error("NSRC must be 1 or 2");
      end
   endgenerate

   logic                       load_live;
   logic [REG_W-1:0]           dst;
   logic [NSRC-1:0]            src_used;
   logic [NSRC-1:0][REG_W-1:0] src_reg;
   logic                       hazard;
   logic                       stall;

   ilk_producer_dec #(
      .INSTR_W(INSTR_W), .OPC_LSB(OPC_LSB), .RT_LSB(RT_LSB), .REG_W(REG_W)
   ) u_prod (
      .instr(idex_instr), .valid(idex_valid),
      .load_live(load_live), .dst(dst)
   );

   ilk_consumer_dec #(
      .INSTR_W(INSTR_W), .OPC_LSB(OPC_LSB), .RS_LSB(RS_LSB),
      .RT_LSB(RT_LSB), .REG_W(REG_W), .NSRC(NSRC)
   ) u_cons (
      .instr(ifid_instr), .src_used(src_used), .src_reg(src_reg)
   );

   ilk_match #(.REG_W(REG_W), .NSRC(NSRC)) u_match (
      .load_live(load_live), .dst(dst),
      .src_used(src_used), .src_reg(src_reg), .hazard(hazard)
   );

   assign stall       = hazard && ifid_valid;
   assign pc_we       = !stall;
   assign ifid_we     = !stall;
   assign idex_bubble = stall;

   always_comb begin
      // R7: holds and bubble move together
      a_r7_outputs_agree: assert (pc_we == ifid_we && idex_bubble == !pc_we);
      // R6: an empty stage never stalls
      a_r6_invalid_no_stall: assert (ifid_valid && idex_valid || !idex_bubble);
   end

endmodule

// File: tb/tb_load_use_interlock.sv
module tb_load_use_interlock;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   int total = 0;
   int bad   = 0;

   logic        pipe_mode = 1'b0;
   logic [31:0] sw_ifid = '0, sw_idex = '0;
   logic        sw_ifid_v = 1'b0, sw_idex_v = 1'b0;

   logic [31:0] pc, ifid_q, idex_q;
   logic        ifid_vq, idex_vq;
   logic [31:0] imem [0:15];

   logic [31:0] d_ifid, d_idex;
   logic        d_ifid_v, d_idex_v;
   logic        pc_we, ifid_we, idex_bubble;

   assign d_ifid   = pipe_mode ? ifid_q  : sw_ifid;
   assign d_idex   = pipe_mode ? idex_q  : sw_idex;
   assign d_ifid_v = pipe_mode ? ifid_vq : sw_ifid_v;
   assign d_idex_v = pipe_mode ? idex_vq : sw_idex_v;

   load_use_interlock dut (
      .ifid_instr(d_ifid), .ifid_valid(d_ifid_v),
      .idex_instr(d_idex), .idex_valid(d_idex_v),
      .pc_we(pc_we), .ifid_we(ifid_we), .idex_bubble(idex_bubble)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc <= '0; ifid_q <= '0; idex_q <= '0; ifid_vq <= 1'b0; idex_vq <= 1'b0;
      end else begin
         if (pc_we) pc <= pc + 1;
         if (ifid_we) begin ifid_q <= imem[pc[3:0]]; ifid_vq <= 1'b1; end
         if (idex_bubble) begin idex_q <= '0; idex_vq <= 1'b0; end
         else begin idex_q <= ifid_q; idex_vq <= ifid_vq; end
      end
   end

   initial begin
      #1_000_000;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   function automatic logic exp_stall(input logic [31:0] p, input logic pv,
                                      input logic [31:0] c, input logic cv);
      logic [5:0] po, co;
      logic [4:0] t;
      logic rs_rd, rt_rd;
      po = p[31:26]; co = c[31:26]; t = p[20:16];
      rs_rd = (co == 6'd0) || (co[5:3] == 3'd1) || (co[5:3] == 3'd4) ||
              (co[5:3] == 3'd5) || (co[5:2] == 4'd1);
      rt_rd = (co == 6'd0) || (co[5:3] == 3'd5) || (co == 6'd4) || (co == 6'd5);
      return pv && cv && (po[5:3] == 3'd4) && (t != 0) &&
             ((rs_rd && c[25:21] == t) || (rt_rd && c[20:16] == t));
   endfunction

   task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic chk_int(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_prog(input string req, input int exp_stalls, input int exp_issue,
                           input logic [31:0] dep);
      int stalls, run, maxrun, issued;
      stalls = 0; run = 0; maxrun = 0; issued = 0;
      rst_n = 1'b0;
      pipe_mode = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         if (idex_bubble) begin stalls++; run++; end else run = 0;
         if (run > maxrun) maxrun = run;
         if (idex_vq && idex_q == dep) issued++;
      end
      chk_int({req, " stall count"}, stalls, exp_stalls);
      chk_int({req, " longest stall run"}, maxrun, exp_stalls > 0 ? 1 : 0);
      chk_int({req, " dependent issued"}, issued, exp_issue);
      pipe_mode = 1'b0;
   endtask

   logic [31:0] lw5, add_dep, addi_ind, lw6_dep, sw_dep;

   initial begin
      lw5      = {6'h23, 5'd1, 5'd5, 16'd0};
      add_dep  = {6'h00, 5'd5, 5'd7, 5'd6, 11'h020};
      addi_ind = {6'h08, 5'd1, 5'd8, 16'd4};
      lw6_dep  = {6'h23, 5'd5, 5'd6, 16'd0};
      sw_dep   = {6'h2b, 5'd2, 5'd6, 16'd0};

      // reset state through the pipeline model: empty stages (R6, R7)
      pipe_mode = 1'b1;
      for (int i = 0; i < 16; i++) imem[i] = '0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R7 reset outputs", {pc_we, ifid_we, idex_bubble}, 3'b110);
      pipe_mode = 1'b0;

      // exhaustive opcode-pair sweep (R1..R7)
      for (int po = 0; po < 64; po++) begin
         for (int co = 0; co < 64; co++) begin
            for (int pat = 0; pat < 6; pat++) begin
               logic [4:0] t, s, r;
               logic e;
               string req;
               t = 5'd5; s = 5'd9; r = 5'd10; sw_ifid_v = 1'b1; sw_idex_v = 1'b1;
               case (pat)
                  0: s = 5'd5;
                  1: r = 5'd5;
                  2: ;
                  3: begin t = 5'd0; s = 5'd0; r = 5'd0; end
                  4: begin s = 5'd5; r = 5'd5; sw_ifid_v = 1'b0; end
                  default: begin s = 5'd5; r = 5'd5; sw_idex_v = 1'b0; end
               endcase
               @(posedge clk);
               sw_idex = {po[5:0], 5'd3, t, 16'h0};
               sw_ifid = {co[5:0], s, r, 16'h0};
               @(negedge clk);
               e = exp_stall(sw_idex, sw_idex_v, sw_ifid, sw_ifid_v);
               if (pat >= 4) req = "R6";
               else if (pat == 3) req = "R5";
               else if (po[5:3] != 3'd4) req = "R4";
               else if (pat == 1) req = "R2";
               else if (!e && pat == 0) req = "R3";
               else req = "R1";
               chk({req, "/R7 sweep"}, {pc_we, ifid_we, idex_bubble}, {!e, !e, e});
            end
         end
      end

      // R8: load then dependent add: one stall, add issues once
      for (int i = 0; i < 16; i++) imem[i] = '0;
      imem[0] = lw5; imem[1] = add_dep;
      run_prog("R8 load-use", 1, 1, add_dep);

      // R8: independent instruction between: no stall
      for (int i = 0; i < 16; i++) imem[i] = '0;
      imem[0] = lw5; imem[1] = addi_ind; imem[2] = add_dep;
      run_prog("R8 separated", 0, 1, add_dep);

      // R8: load chain then store of loaded data: two single stalls
      for (int i = 0; i < 16; i++) imem[i] = '0;
      imem[0] = lw5; imem[1] = lw6_dep; imem[2] = sw_dep;
      run_prog("R8 chain", 2, 1, sw_dep);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule